// File: doc/BRIEF.md
# Multi-Source Reset Controller with Stretch

This block merges four reset requests into one internal system reset. The four requests are a power-on detect level, an active-low external reset pin, a watchdog expiry pulse and a brown-out detect level. The watchdog and brown-out requests only count while their own enable input is set. The external pin first passes a two-flop synchronizer and then a minimum-width filter. The power-on level always counts.

Two resets leave the block. The port reset is a combinational OR of the qualified requests, so it rises as soon as a request becomes active, even if no clock edge occurs. The core reset is active low. It is cleared asynchronously by the same OR and is released synchronously. When the last request clears, a two-flop release chain runs, then a counter holds the core reset for a stretch length chosen by two configuration fields.

A four-bit cause register keeps one sticky flag for each source. Software clears flags by writing ones to them. A power-on event leaves only the power-on flag set.

Top module: `rstctl_top`

## Requirements
- R1: `port_rst_o` is high, with no clock edge needed, whenever `por_det_i` is high, `bod_det_i & bod_en_i` is high, `wdt_expire_i & wdt_rst_en_i` is high, or the filtered external request is active.
- R2: `core_rst_no` is low whenever `port_rst_o` is high.
- R3: After the cycle in which every request has cleared, `core_rst_no` rises at the (3 + D)th rising clock edge. D is the stretch length from R4.
- R4: D is 0 when `start_code_i` = 0. For `start_code_i` values 1, 2 and 3, D = 2^(LOG_SHORT + `clk_code_i`), 2^(LOG_MID + `clk_code_i`) and 2^(LOG_LONG + `clk_code_i`).
- R5: A request that re-asserts while the stretch is counting keeps `core_rst_no` low. The full R3 delay then restarts from the new clear.
- R6: The external request becomes active only after the synchronized pin has been low for more than MIN_LOW clock cycles. A low pulse of MIN_LOW cycles or fewer has no effect on any output.
- R7: A watchdog pulse with `wdt_rst_en_i` low has no effect on any output.
- R8: A brown-out level with `bod_en_i` low has no effect on any output.
- R9: `cause_o` bit 0 is power-on, bit 1 external, bit 2 watchdog and bit 3 brown-out. A qualified request sets its bit. A high `por_det_i` forces `cause_o` to 4'b0001 at once.
- R10: A one on `flag_clr_i[k]` clears `cause_o[k]` at the next clock edge. A request that sets bit k in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running clock |
| por_det_i | input | 1 | Power-on detect level, active high |
| ext_rst_ni | input | 1 | External reset pin, active low, asynchronous |
| wdt_expire_i | input | 1 | Watchdog expiry pulse, synchronous to `clk_i` |
| wdt_rst_en_i | input | 1 | Enable that lets the watchdog pulse cause a reset |
| bod_det_i | input | 1 | Brown-out detect level, active high |
| bod_en_i | input | 1 | Enable that lets the brown-out level cause a reset |
| start_code_i | input | 2 | Startup-time field of the stretch selection |
| clk_code_i | input | 2 | Clock-select field that scales the stretch |
| flag_clr_i | input | 4 | Write-one-to-clear strobes for the cause flags |
| port_rst_o | output | 1 | Immediate port reset, active high |
| core_rst_no | output | 1 | Stretched core reset, active low |
| cause_o | output | 4 | Sticky reset cause flags |

## Verification
The bench sets MIN_LOW to 4, so an external pulse at the filter boundary (4 cycles rejected, 5 cycles accepted) fits in a few cycles. LOG_SHORT, LOG_MID and LOG_LONG are set to 2, 3 and 5. With these values every `start_code_i` row of R4, including the zero-length setting and a clock-select scale, gives a stretch of at most 32 cycles. Each stretch length can then be measured exactly, and so can the restart after a re-assertion mid-stretch.

// File: rtl/rstctl_pkg.sv
package rstctl_pkg;
  localparam int unsigned SRC_N = 4;

  typedef enum logic [1:0] {
    SRC_POR = 2'd0,
    SRC_EXT = 2'd1,
    SRC_WDT = 2'd2,
    SRC_BOD = 2'd3
  } src_e;
endpackage

// File: rtl/rstctl_pin_filter.sv
module rstctl_pin_filter #(
  parameter int unsigned MIN_LOW = 16
) (
  input  logic clk_i,
  input  logic arst_ni,
  input  logic pin_ni,
  output logic active_o
);
  localparam int unsigned CW = $clog2(MIN_LOW + 1);
  localparam logic [CW-1:0] LIMIT = CW'(MIN_LOW);

  logic          meta_q, sync_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          low_sync;

  assign low_sync = !sync_q;

  always_comb begin
    cnt_d = '0;
    if (low_sync) begin
      cnt_d = (cnt_q == LIMIT) ? cnt_q : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      meta_q <= 1'b1;
      sync_q <= 1'b1;
      cnt_q  <= '0;
    end else begin
      meta_q <= pin_ni;
      sync_q <= meta_q;
      cnt_q  <= cnt_d;
    end
  end

  assign active_o = low_sync && (cnt_q == LIMIT);

  // R6: an active request needs the pin to have been low in the prior cycle
  p_needs_low_r6: assert property (@(posedge clk_i) disable iff (!arst_ni)
    active_o |-> $past(low_sync));
endmodule

// File: rtl/rstctl_stretch.sv
module rstctl_stretch #(
  parameter int unsigned LOG_SHORT = 4,
  parameter int unsigned LOG_MID   = 9,
  parameter int unsigned LOG_LONG  = 12,
  parameter int unsigned CNT_W     = LOG_LONG + 4
) (
  input  logic       clk_i,
  input  logic       arst_ni,
  input  logic [1:0] start_code_i,
  input  logic [1:0] clk_code_i,
  output logic       rel_o
);
  logic             s1_q, s2_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;
  logic [CNT_W-1:0] delay;
  logic             cnt_en;

  always_comb begin
    unique case (start_code_i)
      2'd0:    delay = '0;
      2'd1:    delay = CNT_W'(1) << (LOG_SHORT + int'(clk_code_i));
      2'd2:    delay = CNT_W'(1) << (LOG_MID + int'(clk_code_i));
      default: delay = CNT_W'(1) << (LOG_LONG + int'(clk_code_i));
    endcase
  end

  assign cnt_en = s2_q && !done_q;

  always_comb begin
    cnt_d  = cnt_q;
    done_d = done_q;
    if (cnt_en) begin
      if (cnt_q == delay) begin
        done_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      s1_q   <= 1'b1;
      s2_q   <= s1_q;
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign rel_o = done_q;

  // R3: release happens only once the count has reached the selected delay
  p_release_count_r3: assert property (@(posedge clk_i) disable iff (!arst_ni)
    $rose(done_q) |-> ($past(cnt_q) == $past(delay)));
  // R4: the counter never passes the selected delay
  p_no_overflow_r4: assert property (@(posedge clk_i) disable iff (!arst_ni)
    !done_q |-> (cnt_q <= delay));
endmodule

// File: rtl/rstctl_cause.sv
module rstctl_cause #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         por_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] cause_o
);
  localparam logic [N-1:0] POR_VAL = N'(1);

  logic [N-1:0] cause_q, cause_d;

  always_comb begin
    cause_d = (cause_q & ~clr_i) | set_i;
  end

  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni) begin
      cause_q <= POR_VAL;
    end else begin
      cause_q <= cause_d;
    end
  end

  assign cause_o = cause_q;

  for (genvar k = 0; k < N; k++) begin : g_flag
    // R9: a qualified request leaves its flag set
    p_set_r9: assert property (@(posedge clk_i) disable iff (!por_ni)
      set_i[k] |=> cause_q[k]);
    // R10: a clear strobe without a competing set empties the flag
    p_w1c_r10: assert property (@(posedge clk_i) disable iff (!por_ni)
      (clr_i[k] && !set_i[k]) |=> !cause_q[k]);
  end
endmodule

// File: rtl/rstctl_top.sv
module rstctl_top #(
  parameter int unsigned MIN_LOW   = 16,
  parameter int unsigned LOG_SHORT = 4,
  parameter int unsigned LOG_MID   = 9,
  parameter int unsigned LOG_LONG  = 12
) (
  input  logic       clk_i,
  input  logic       por_det_i,
  input  logic       ext_rst_ni,
  input  logic       wdt_expire_i,
  input  logic       wdt_rst_en_i,
  input  logic       bod_det_i,
  input  logic       bod_en_i,
  input  logic [1:0] start_code_i,
  input  logic [1:0] clk_code_i,
  input  logic [3:0] flag_clr_i,
  output logic       port_rst_o,
  output logic       core_rst_no,
  output logic [3:0] cause_o
);
  import rstctl_pkg::*;

  localparam int unsigned CNT_W = LOG_LONG + 4;

  logic             por_n;
  logic             ext_active;
  logic             wdt_hit;
  logic             bod_hit;
  logic             src_any;
  logic             core_arst_n;
  logic [SRC_N-1:0] set_vec;

  assign por_n       = !por_det_i;
  assign wdt_hit     = wdt_expire_i && wdt_rst_en_i;
  assign bod_hit     = bod_det_i && bod_en_i;
  assign src_any     = por_det_i || ext_active || wdt_hit || bod_hit;
  assign core_arst_n = !src_any;
  assign port_rst_o  = src_any;

  always_comb begin
    set_vec          = '0;
    set_vec[SRC_EXT] = ext_active;
    set_vec[SRC_WDT] = wdt_hit;
    set_vec[SRC_BOD] = bod_hit;
  end

  rstctl_pin_filter #(
    .MIN_LOW (MIN_LOW)
  ) i_filter (
    .clk_i    (clk_i),
    .arst_ni  (por_n),
    .pin_ni   (ext_rst_ni),
    .active_o (ext_active)
  );

  rstctl_stretch #(
    .LOG_SHORT (LOG_SHORT),
    .LOG_MID   (LOG_MID),
    .LOG_LONG  (LOG_LONG),
    .CNT_W     (CNT_W)
  ) i_stretch (
    .clk_i        (clk_i),
    .arst_ni      (core_arst_n),
    .start_code_i (start_code_i),
    .clk_code_i   (clk_code_i),
    .rel_o        (core_rst_no)
  );

  rstctl_cause #(
    .N (SRC_N)
  ) i_cause (
    .clk_i   (clk_i),
    .por_ni  (por_n),
    .set_i   (set_vec),
    .clr_i   (flag_clr_i),
    .cause_o (cause_o)
  );

  // R2: the core reset stays low while any request is active
  p_core_held_r2: assert property (@(posedge clk_i) disable iff (por_det_i)
    port_rst_o |-> !core_rst_no);
  // R7: the watchdog flag rises only after an enabled expiry
  p_wdt_gated_r7: assert property (@(posedge clk_i) disable iff (por_det_i)
    $rose(cause_o[SRC_WDT]) |-> $past(wdt_expire_i && wdt_rst_en_i));
  // R8: the brown-out flag rises only after an enabled detection
  p_bod_gated_r8: assert property (@(posedge clk_i) disable iff (por_det_i)
    $rose(cause_o[SRC_BOD]) |-> $past(bod_det_i && bod_en_i));
endmodule

// File: tb/test_rstctl_top.sv
module test_rstctl_top;
  localparam int unsigned MIN_LOW = 4;
  localparam int unsigned LS = 2;
  localparam int unsigned LM = 3;
  localparam int unsigned LL = 5;

  logic       clk = 1'b0;
  logic       por_det, ext_n, wdt, wdt_en, bod, bod_en;
  logic [1:0] start_code, clk_code;
  logic [3:0] flag_clr;
  logic       port_rst, core_rst_n;
  logic [3:0] cause;

  int n_chk  = 0;
  int n_fail = 0;
  int exp_q[$];
  bit port_seen = 1'b0;
  bit finished  = 1'b0;

  always #5 clk = ~clk;

  rstctl_top #(
    .MIN_LOW (MIN_LOW), .LOG_SHORT (LS), .LOG_MID (LM), .LOG_LONG (LL)
  ) i_rstctl_top (
    .clk_i (clk), .por_det_i (por_det), .ext_rst_ni (ext_n),
    .wdt_expire_i (wdt), .wdt_rst_en_i (wdt_en), .bod_det_i (bod),
    .bod_en_i (bod_en), .start_code_i (start_code), .clk_code_i (clk_code),
    .flag_clr_i (flag_clr), .port_rst_o (port_rst), .core_rst_no (core_rst_n),
    .cause_o (cause)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int stretch(input int s, input int c);
    if (s == 0) return 0;
    if (s == 1) return 1 << (LS + c);
    if (s == 2) return 1 << (LM + c);
    return 1 << (LL + c);
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  always @(posedge port_rst) port_seen = 1'b1;

  // monitor: counts edges since the requests cleared and scores each release
  initial begin
    int  since = 0;
    bit  prev_core = 1'b0;
    forever begin
      @(posedge clk);
      #2;
      if (port_rst) since = 0;
      else since++;
      if (core_rst_n && !prev_core) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R3 unexpected release", since, -1);
        end else begin
          int e;
          e = exp_q.pop_front();
          check(since == e, "R3/R4 release edge count", since, e);
        end
      end
      prev_core = core_rst_n;
    end
  end

  initial begin
    #(200000 * 10);
    check(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    por_det = 1'b1; ext_n = 1'b1; wdt = 1'b0; wdt_en = 1'b0;
    bod = 1'b0; bod_en = 1'b0; flag_clr = '0; start_code = 2'd1; clk_code = 2'd0;
    #1;
    check(port_rst == 1'b1, "R1 port reset with no clock edge", port_rst, 1);
    check(core_rst_n == 1'b0, "R2 core held at power-on", core_rst_n, 0);
    check(cause == 4'b0001, "R9 power-on cause", cause, 1);
    cyc(3);
    por_det = 1'b0;
    exp_q.push_back(3 + stretch(1, 0));
    cyc(12);
    check(core_rst_n == 1'b1, "R3 released after power-on", core_rst_n, 1);
    check(cause == 4'b0001, "R9 cause after power-on", cause, 1);

    // R8: brown-out without enable
    port_seen = 1'b0;
    bod = 1'b1;
    cyc(3);
    bod = 1'b0;
    cyc(2);
    check(!port_seen, "R8 disabled brown-out port", port_seen, 0);
    check(core_rst_n == 1'b1, "R8 disabled brown-out core", core_rst_n, 1);
    check(cause == 4'b0001, "R8 disabled brown-out cause", cause, 1);

    // R8/R1: enabled brown-out, stretch (2,1)
    start_code = 2'd2; clk_code = 2'd1; bod_en = 1'b1;
    cyc(1);
    bod = 1'b1;
    #1;
    check(port_rst == 1'b1, "R1 brown-out immediate", port_rst, 1);
    cyc(3);
    check(core_rst_n == 1'b0, "R2 core held by brown-out", core_rst_n, 0);
    bod = 1'b0;
    exp_q.push_back(3 + stretch(2, 1));
    cyc(25);
    check(cause == 4'b1001, "R8 brown-out cause", cause, 9);

    // R10: write-one clear
    flag_clr = 4'b1001;
    cyc(1);
    flag_clr = '0;
    check(cause == 4'b0000, "R10 flags cleared", cause, 0);

    // R10: set wins over clear; long stretch (3,0)
    start_code = 2'd3; clk_code = 2'd0;
    cyc(1);
    bod = 1'b1; flag_clr = 4'b1000;
    cyc(1);
    flag_clr = '0;
    check(cause[3] == 1'b1, "R10 set wins over clear", cause[3], 1);
    bod = 1'b0;
    exp_q.push_back(3 + stretch(3, 0));
    cyc(40);
    flag_clr = 4'b1000;
    cyc(1);
    flag_clr = '0;

    // R4: zero stretch
    start_code = 2'd0; clk_code = 2'd2;
    cyc(1);
    bod = 1'b1;
    cyc(2);
    bod = 1'b0;
    exp_q.push_back(3);
    cyc(8);

    // R5: re-assertion during stretch restarts it
    start_code = 2'd2; clk_code = 2'd0;
    cyc(1);
    bod = 1'b1;
    cyc(2);
    bod = 1'b0;
    cyc(5);
    check(core_rst_n == 1'b0, "R5 still stretching", core_rst_n, 0);
    bod = 1'b1;
    cyc(1);
    bod = 1'b0;
    exp_q.push_back(3 + stretch(2, 0));
    cyc(16);
    check(core_rst_n == 1'b1, "R5 released after restart", core_rst_n, 1);
    flag_clr = 4'b1000;
    cyc(1);
    flag_clr = '0;

    // R7: watchdog without enable
    port_seen = 1'b0;
    wdt = 1'b1;
    cyc(1);
    wdt = 1'b0;
    cyc(2);
    check(!port_seen, "R7 disabled watchdog port", port_seen, 0);
    check(core_rst_n == 1'b1 && cause == 4'b0000, "R7 disabled watchdog core/cause", cause, 0);

    // R7: enabled watchdog, stretch (1,0)
    start_code = 2'd1; clk_code = 2'd0; wdt_en = 1'b1;
    cyc(1);
    wdt = 1'b1;
    #1;
    check(port_rst == 1'b1, "R1 watchdog immediate", port_rst, 1);
    cyc(1);
    wdt = 1'b0;
    exp_q.push_back(3 + stretch(1, 0));
    cyc(10);
    check(cause == 4'b0100, "R7 watchdog cause", cause, 4);

    // R6: pulse of MIN_LOW cycles is ignored
    port_seen = 1'b0;
    ext_n = 1'b0;
    cyc(MIN_LOW);
    ext_n = 1'b1;
    cyc(6);
    check(!port_seen, "R6 short pulse port", port_seen, 0);
    check(core_rst_n == 1'b1 && cause[1] == 1'b0, "R6 short pulse core/cause", cause, 4);

    // R6: pulse of MIN_LOW+1 cycles resets
    port_seen = 1'b0;
    ext_n = 1'b0;
    cyc(MIN_LOW + 1);
    ext_n = 1'b1;
    exp_q.push_back(4 + stretch(1, 0));
    cyc(14);
    check(port_seen, "R6 long pulse port", port_seen, 1);
    check(cause == 4'b0110, "R6 external cause", cause, 6);

    // R9: power-on again forces cause to 0001 at once
    por_det = 1'b1;
    #1;
    check(cause == 4'b0001, "R9 power-on clears others", cause, 1);
    cyc(2);
    por_det = 1'b0;
    exp_q.push_back(3 + stretch(1, 0));
    cyc(12);
    check(exp_q.size() == 0, "R3 all releases observed", exp_q.size(), 0);
    finish_run();
  end
endmodule